// File: doc/BRIEF.md
# Multi-Core Test Decompression Sequencer

This controller steers broadcast tester data into the per-core sequential linear decompressors of a multi-core chip under test. Each cycle the tester channels carry one slice, and that slice reaches every decompressor whose load enable is high. The controller decides which cores receive the slices, which cores shift their scan chains, and when each core captures.

Each decompression starts with a four-word descriptor read from the tester channels. The first word gives how many chained core groups take part (one to three). The next three words give one core-membership vector per group. The groups then run one after another. Each group shifts for as many cycles as the longest scan chain among its member cores, and then captures for one cycle. During the final q shift cycles of a group, the next group's decompressors also take the broadcast slices while their scan shifting stays off. The free variables in those slices are therefore carried from one group into the next without any buffer. Per-core scan lengths and q come from static configuration inputs.

State machine states: `ST_IDLE` (waits for `more_cubes`, takes the count word), `ST_RD_G1`, `ST_RD_G2`, `ST_RD_G3` (take the membership words), `ST_SHIFT` (a group loads and shifts), `ST_CAPTURE` (a one-cycle capture), `ST_DONE` (end-of-decompression pulse) and `ST_ERR` (rejected descriptor). Transitions:
- `ST_IDLE`→`ST_RD_G1` when `more_cubes` is high.
- `ST_RD_G1`→`ST_RD_G2`→`ST_RD_G3`, unconditionally.
- `ST_RD_G3`→`ST_ERR` on a bad descriptor, otherwise `ST_RD_G3`→`ST_SHIFT`.
- `ST_SHIFT`→`ST_CAPTURE` on the last shift cycle.
- `ST_CAPTURE`→`ST_SHIFT` when another group follows, otherwise `ST_CAPTURE`→`ST_DONE`.
- `ST_DONE`→`ST_IDLE` and `ST_ERR`→`ST_IDLE`.

Top module: `tdc_seq`

## Requirements
- R1: After reset all per-core outputs, `busy`, `done` and `desc_err` are low, and the block waits in idle. It stays idle, with every output low, as long as `more_cubes` is low.
- R2: The descriptor is taken on four consecutive cycles, one word per cycle:
  - Word 1 is taken in the idle cycle where `more_cubes` is high. Its group count is in `chan[2:0]`.
  - Words 2, 3 and 4 follow, each with a membership vector for groups 1, 2 and 3 in `chan[NUM_CORES-1:0]`. Bit i of a vector is core i.
  - All other channel bits are ignored, and groups beyond the count are treated as empty.
- R3: While the descriptor is being read, every load, shift and capture output is low and `busy` is high from the second descriptor word onward. Slices on the channels reach no decompressor.
- R4: Starting the cycle after the last descriptor word, group 1 shifts. Each group shifts for L cycles, where L is the largest configured scan length among its members, and a length of 0 counts as 1. In every shift cycle, `dec_load_en` and `scan_shift_en` both include exactly the group's members.
- R5: While a group that has a successor is shifting, the successor's cores are added to `dec_load_en` during the final `cfg_q` shift cycles. Their `scan_shift_en` stays low during those cycles. With `cfg_q` = 0 there is no pre-load. If `cfg_q` is L or more, the pre-load covers every shift cycle. The last group pre-loads nothing.
- R6: A group's last shift cycle is followed by exactly one capture cycle. In that cycle `capture` equals the group's members, and no load or shift enable is active.
- R7: The cycle after a capture, the next group starts shifting if one exists. Otherwise `done` pulses for one cycle with `busy` low, and the block returns to idle.
- R8: In the following cases the descriptor is ignored: a count of 0 or above 3, an empty group within the count, or two consecutive groups that share a core. `desc_err` then pulses for one cycle with all enables low, and the block returns to idle without running any group. Groups 1 and 3 may share cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| more_cubes | input | 1 | Tester has another decompression to run |
| chan | input | CHAN_W | Tester channel slice (descriptor words while parsing) |
| cfg_scan_len | input | NUM_CORES*LEN_W | Scan length per core, core i in bits [i*LEN_W +: LEN_W] |
| cfg_q | input | Q_W | Number of trailing shift cycles used for pre-loading |
| dec_load_en | output | NUM_CORES | Decompressor load enable per core |
| scan_shift_en | output | NUM_CORES | Scan shift enable per core |
| capture | output | NUM_CORES | One-cycle capture pulse per core |
| busy | output | 1 | A decompression is being parsed or run |
| done | output | 1 | One-cycle pulse after the final capture |
| desc_err | output | 1 | One-cycle pulse for a rejected descriptor |

## Verification
The bench targets the edges of the pre-load window. With q = 0, a design that pre-loads anyway would raise the next group's load enable too early. With q above the group length, a design that compares wrongly would skip the early cycles. A group whose longest member is not core 0 catches a max computation that only looks at one core. A length-0 core catches a shift phase that wraps its counter. Three-group runs where groups 1 and 3 overlap catch a checker that forbids legal reuse. Overlapping neighbours, an empty group and counts of 0 and 5 catch a design that runs a bad descriptor instead of flagging it. Random upper channel bits catch a parser that reads outside its fields.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int MAX_GROUPS = 3;
    localparam int CNT_W      = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_G1,
        ST_RD_G2,
        ST_RD_G3,
        ST_SHIFT,
        ST_CAPTURE,
        ST_DONE,
        ST_ERR
    } tdc_state_e;
endpackage

// File: rtl/tdc_maxlen.sv
module tdc_maxlen #(
    parameter int NUM_CORES = 4,
    parameter int LEN_W     = 8
) (
    input  logic [NUM_CORES-1:0]       mask,
    input  logic [NUM_CORES*LEN_W-1:0] lens,
    output logic [LEN_W-1:0]           max_len
);
    logic [LEN_W-1:0] best;

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            if (mask[i] && lens[i*LEN_W +: LEN_W] > best)
                best = lens[i*LEN_W +: LEN_W];
        end
        // a zero length still gives one shift cycle
        max_len = (best == '0) ? LEN_W'(1) : best;
    end
endmodule

// File: rtl/tdc_desc_check.sv
module tdc_desc_check #(
    parameter int NUM_CORES = 4
) (
    input  logic [tdc_pkg::CNT_W-1:0] count,
    input  logic [NUM_CORES-1:0]      grp_a,
    input  logic [NUM_CORES-1:0]      grp_b,
    input  logic [NUM_CORES-1:0]      grp_c,
    output logic                      bad
);
    logic bad_count, bad_a, bad_b, bad_c;

    always_comb begin
        bad_count = (count == '0) || (count > tdc_pkg::CNT_W'(tdc_pkg::MAX_GROUPS));
        bad_a     = (grp_a == '0);
        bad_b     = (count >= 3'd2) && ((grp_b == '0) || ((grp_a & grp_b) != '0));
        bad_c     = (count == 3'd3) && ((grp_c == '0) || ((grp_b & grp_c) != '0));
        bad       = bad_count || bad_a || bad_b || bad_c;
    end
endmodule

// File: rtl/tdc_seq.sv
module tdc_seq #(
    parameter int NUM_CORES = 4,
    parameter int CHAN_W    = 8,
    parameter int LEN_W     = 8,
    parameter int Q_W       = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       more_cubes,
    input  logic [CHAN_W-1:0]          chan,
    input  logic [NUM_CORES*LEN_W-1:0] cfg_scan_len,
    input  logic [Q_W-1:0]             cfg_q,
    output logic [NUM_CORES-1:0]       dec_load_en,
    output logic [NUM_CORES-1:0]       scan_shift_en,
    output logic [NUM_CORES-1:0]       capture,
    output logic                       busy,
    output logic                       done,
    output logic                       desc_err
);
    import tdc_pkg::*;

    localparam int GRP_W = 2;

    tdc_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;
    logic [NUM_CORES-1:0]   mem_q [MAX_GROUPS];
    logic [NUM_CORES-1:0]   mem_d [MAX_GROUPS];
    logic [GRP_W-1:0]       grp_q, grp_d;
    logic [LEN_W-1:0]       rem_q, rem_d;

    logic [NUM_CORES-1:0]   chan_mem, mem_cur, mem_next, len_mask;
    logic [LEN_W-1:0]       start_len, q_ext;
    logic                   desc_bad, in_window;

    assign chan_mem = chan[NUM_CORES-1:0];
    assign q_ext    = LEN_W'(cfg_q);

    always_comb begin
        mem_cur  = '0;
        mem_next = '0;
        unique case (grp_q)
            2'd0: begin mem_cur = mem_q[0]; mem_next = mem_q[1]; end
            2'd1: begin mem_cur = mem_q[1]; mem_next = mem_q[2]; end
            2'd2: begin mem_cur = mem_q[2]; mem_next = '0;       end
            default: ;
        endcase
    end

    assign len_mask  = (state_q == ST_CAPTURE) ? mem_next : mem_q[0];
    assign in_window = (rem_q <= q_ext);

    tdc_maxlen #(.NUM_CORES(NUM_CORES), .LEN_W(LEN_W)) u_maxlen (
        .mask    (len_mask),
        .lens    (cfg_scan_len),
        .max_len (start_len)
    );

    tdc_desc_check #(.NUM_CORES(NUM_CORES)) u_check (
        .count (cnt_q),
        .grp_a (mem_q[0]),
        .grp_b (mem_q[1]),
        .grp_c (chan_mem),
        .bad   (desc_bad)
    );

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        mem_d   = mem_q;
        grp_d   = grp_q;
        rem_d   = rem_q;
        unique case (state_q)
            ST_IDLE: if (more_cubes) begin
                cnt_d   = chan[CNT_W-1:0];
                state_d = ST_RD_G1;
            end
            ST_RD_G1: begin
                mem_d[0] = chan_mem;
                state_d  = ST_RD_G2;
            end
            ST_RD_G2: begin
                mem_d[1] = (cnt_q >= 3'd2) ? chan_mem : '0;
                state_d  = ST_RD_G3;
            end
            ST_RD_G3: begin
                mem_d[2] = (cnt_q == 3'd3) ? chan_mem : '0;
                if (desc_bad) begin
                    state_d = ST_ERR;
                end else begin
                    grp_d   = '0;
                    rem_d   = start_len;
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (rem_q == LEN_W'(1)) state_d = ST_CAPTURE;
                else                    rem_d   = rem_q - LEN_W'(1);
            end
            ST_CAPTURE: begin
                if (mem_next != '0) begin
                    grp_d   = grp_q + GRP_W'(1);
                    rem_d   = start_len;
                    state_d = ST_SHIFT;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            ST_ERR:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            grp_q   <= '0;
            rem_q   <= '0;
            for (int g = 0; g < MAX_GROUPS; g++) mem_q[g] <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            grp_q   <= grp_d;
            rem_q   <= rem_d;
            for (int g = 0; g < MAX_GROUPS; g++) mem_q[g] <= mem_d[g];
        end
    end

    // outputs
    always_comb begin
        dec_load_en   = '0;
        scan_shift_en = '0;
        capture       = '0;
        busy          = 1'b0;
        done          = 1'b0;
        desc_err      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_G1, ST_RD_G2, ST_RD_G3: busy = 1'b1;
            ST_SHIFT: begin
                busy          = 1'b1;
                scan_shift_en = mem_cur;
                dec_load_en   = mem_cur | (in_window ? mem_next : '0);
            end
            ST_CAPTURE: begin
                busy    = 1'b1;
                capture = mem_cur;
            end
            ST_DONE: done     = 1'b1;
            ST_ERR:  desc_err = 1'b1;
            default: ;
        endcase
    end

    // assertions
    assert_parse_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_RD_G1, ST_RD_G2, ST_RD_G3}) |->
            (dec_load_en == '0 && scan_shift_en == '0 && capture == '0));

    assert_shift_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_shift_en & ~dec_load_en) == '0);

    assert_preload_no_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> ((mem_next & scan_shift_en) == '0));

    assert_capture_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture != '0) |-> (dec_load_en == '0 && scan_shift_en == '0));

    assert_capture_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture != '0) |=> (capture == '0));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err |=> (!busy && scan_shift_en == '0 && dec_load_en == '0));

    assert_err_after_parse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(desc_err) |-> ($past(state_q) == ST_RD_G3));
endmodule

// File: tb/sim_tdc_seq.sv
module sim_tdc_seq;
    localparam int NUM_CORES = 4;
    localparam int CHAN_W    = 8;
    localparam int LEN_W     = 8;
    localparam int Q_W       = 4;

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic                       more_cubes;
    logic [CHAN_W-1:0]          chan;
    logic [NUM_CORES*LEN_W-1:0] cfg_scan_len;
    logic [Q_W-1:0]             cfg_q;
    logic [NUM_CORES-1:0]       dec_load_en, scan_shift_en, capture;
    logic                       busy, done, desc_err;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    tdc_seq #(.NUM_CORES(NUM_CORES), .CHAN_W(CHAN_W), .LEN_W(LEN_W), .Q_W(Q_W)) u0 (
        .clk(clk), .rst_n(rst_n), .more_cubes(more_cubes), .chan(chan),
        .cfg_scan_len(cfg_scan_len), .cfg_q(cfg_q),
        .dec_load_en(dec_load_en), .scan_shift_en(scan_shift_en), .capture(capture),
        .busy(busy), .done(done), .desc_err(desc_err)
    );

    function automatic int bmax(input logic [NUM_CORES-1:0] m);
        int best = 0;
        for (int i = 0; i < NUM_CORES; i++)
            if (m[i] && int'(cfg_scan_len[i*LEN_W +: LEN_W]) > best)
                best = int'(cfg_scan_len[i*LEN_W +: LEN_W]);
        return (best == 0) ? 1 : best;
    endfunction

    function automatic bit bbad(input int cnt, input logic [NUM_CORES-1:0] a,
                                input logic [NUM_CORES-1:0] b, input logic [NUM_CORES-1:0] c);
        if (cnt < 1 || cnt > 3) return 1'b1;
        if (a == 0) return 1'b1;
        if (cnt >= 2 && (b == 0 || (a & b) != 0)) return 1'b1;
        if (cnt == 3 && (c == 0 || (b & c) != 0)) return 1'b1;
        return 1'b0;
    endfunction

    // compare all outputs in the current cycle (called just after a negedge)
    task automatic chk(input string tag, input logic [NUM_CORES-1:0] el,
                       input logic [NUM_CORES-1:0] es, input logic [NUM_CORES-1:0] ec,
                       input logic eb, input logic ed, input logic ee);
        checks++;
        if ({dec_load_en, scan_shift_en, capture, busy, done, desc_err} !==
            {el, es, ec, eb, ed, ee}) begin
            errors++;
            $display("FAIL %s: got load=%b shift=%b cap=%b busy=%b done=%b err=%b, exp load=%b shift=%b cap=%b busy=%b done=%b err=%b",
                     tag, dec_load_en, scan_shift_en, capture, busy, done, desc_err,
                     el, es, ec, eb, ed, ee);
        end
    endtask

    task automatic set_cfg(input int l0, input int l1, input int l2, input int l3, input int q);
        cfg_scan_len = {LEN_W'(l3), LEN_W'(l2), LEN_W'(l1), LEN_W'(l0)};
        cfg_q        = Q_W'(q);
    endtask

    // drive one descriptor and check the whole decompression cycle by cycle
    task automatic run_desc(input int cnt, input logic [NUM_CORES-1:0] a,
                            input logic [NUM_CORES-1:0] b, input logic [NUM_CORES-1:0] c);
        logic [NUM_CORES-1:0] grp [3];
        int ng;
        bit bad;
        bad = bbad(cnt, a, b, c);
        grp[0] = a;
        grp[1] = (cnt >= 2) ? b : '0;
        grp[2] = (cnt == 3) ? c : '0;
        ng = bad ? 0 : cnt;
        @(negedge clk);
        more_cubes = 1'b1;
        chan = {5'($urandom), 3'(cnt)};
        @(negedge clk);
        more_cubes = 1'b0;
        chk("R3 parse word2", '0, '0, '0, 1'b1, 1'b0, 1'b0);
        chan = {4'($urandom), a};
        @(negedge clk);
        chk("R3 parse word3", '0, '0, '0, 1'b1, 1'b0, 1'b0);
        chan = {4'($urandom), b};
        @(negedge clk);
        chk("R3 parse word4", '0, '0, '0, 1'b1, 1'b0, 1'b0);
        chan = {4'($urandom), c};
        if (bad) begin
            @(negedge clk);
            chk("R8 error pulse", '0, '0, '0, 1'b0, 1'b0, 1'b1);
            chan = CHAN_W'($urandom);
        end else begin
            for (int g = 0; g < ng; g++) begin
                int len;
                logic [NUM_CORES-1:0] nxt;
                len = bmax(grp[g]);
                nxt = (g + 1 < ng) ? grp[g+1] : '0;
                for (int t = 0; t < len; t++) begin
                    logic [NUM_CORES-1:0] el;
                    @(negedge clk);
                    el = grp[g] | (((len - t) <= int'(cfg_q)) ? nxt : '0);
                    chk((nxt != 0 && int'(cfg_q) > 0) ? "R5 preload shift" : "R4 group shift",
                        el, grp[g], '0, 1'b1, 1'b0, 1'b0);
                    chan = CHAN_W'($urandom);
                end
                @(negedge clk);
                chk("R6 capture", '0, '0, grp[g], 1'b1, 1'b0, 1'b0);
            end
            @(negedge clk);
            chk("R7 done pulse", '0, '0, '0, 1'b0, 1'b1, 1'b0);
        end
        @(negedge clk);
        chk("R7 back to idle", '0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0;
        more_cubes = 1'b0;
        chan = '0;
        set_cfg(5, 3, 7, 2, 2);
        repeat (3) @(negedge clk);
        chk("R1 reset state", '0, '0, '0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        chan = 8'hFB;
        repeat (4) @(negedge clk);
        chk("R1 idle without more_cubes", '0, '0, '0, 1'b0, 1'b0, 1'b0);

        // directed cases (R2 field positions, upper bits random)
        run_desc(1, 4'b0101, 4'b1111, 4'b1111);       // single group, R2 unused groups ignored
        run_desc(2, 4'b0001, 4'b0110, 4'b0000);       // two groups, q=2
        set_cfg(5, 3, 7, 2, 0);
        run_desc(2, 4'b0100, 4'b0011, 4'b0000);       // R5 q=0: no preload
        set_cfg(2, 6, 3, 4, 9);
        run_desc(3, 4'b0001, 4'b1010, 4'b0101);       // R5 q above length; groups 1,3 share core 0
        set_cfg(0, 0, 4, 0, 1);
        run_desc(2, 4'b0011, 4'b1000, 4'b0000);       // R4 zero lengths count as one
        run_desc(0, 4'b0001, 4'b0000, 4'b0000);       // R8 count 0
        run_desc(5, 4'b0001, 4'b0010, 4'b0100);       // R8 count too big
        run_desc(2, 4'b0011, 4'b0110, 4'b0000);       // R8 neighbours overlap
        run_desc(3, 4'b0001, 4'b0010, 4'b0000);       // R8 empty third group
        run_desc(3, 4'b0001, 4'b0010, 4'b0110);       // R8 groups 2 and 3 overlap

        // random decompressions
        for (int n = 0; n < 60; n++) begin
            int cnt;
            logic [NUM_CORES-1:0] a, b, c;
            set_cfg(int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                    int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                    int'($urandom_range(0, 6)));
            cnt = int'($urandom_range(0, 4));
            a = NUM_CORES'($urandom);
            b = NUM_CORES'($urandom);
            c = NUM_CORES'($urandom);
            if ((n % 3) != 0) begin      // bias toward legal descriptors
                if (cnt == 0 || cnt == 4) cnt = 2;
                if (a == 0) a = 4'b0001;
                b = b & ~a;
                if (b == 0) b = ~a;
                if (b == 0) cnt = 1;
                c = c & ~b;
                if (c == 0) c = ~b;
            end
            run_desc(cnt, a, b, c);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule